// File: doc/BRIEF.md
# Double-Shift Funnel Unit

This combinational unit performs the two-operand shift used for multi-word shifts. A destination word moves left or right by a count, and the bit positions it vacates are refilled from a second word instead of with zeros. The operation is defined for 16-bit and 32-bit operands. The second word is an input only; the unit never drives it back. Along with the shifted destination, the unit produces carry, overflow, sign, zero and parity values. Each group of flags has its own write enable, so the surrounding datapath knows which flags to commit.

The count operand is 8 bits wide, but only its low five bits are used. A count of zero is a no-operation. At 16-bit width, a masked count of 16 or more is rejected on a dedicated output, and the unit then asks for no flag update. Callers chain several operations to build packed words. One example gathers a nibble from each of four words. Another packs a calendar date from its year, day and month fields.

Top module: `dshift_unit`

## Requirements
- R1: With dir_i=0 (left) and a masked count n in 1..W-1, where W is 32 when wide_i=1 and 16 when wide_i=0, res_o equals the upper W bits of the 2W-bit concatenation {dst, src} shifted left by n.
- R2: With dir_i=1 (right) and a valid nonzero n, res_o equals the lower W bits of {src, dst} shifted right by n.
- R3: For a valid nonzero n, cf_we_o=1 and cf_o holds the last destination bit shifted out: dst[W-n] for a left shift and dst[n-1] for a right shift.
- R4: Only cnt_i[4:0] is used as the count. Bits 7..5 have no effect.
- R5: When the masked count is zero, res_o equals the W-bit destination, and cf_we_o, of_we_o, szp_we_o and cnt_bad_o are all 0.
- R6: When wide_i=0 and the masked count is 16 or more, cnt_bad_o=1, res_o equals the 16-bit destination, and all three flag enables are 0.
- R7: of_we_o=1 only for a masked count of exactly 1, valid at the selected width. Then of_o is 1 when bit W-1 of the result differs from bit W-1 of the destination.
- R8: For a valid nonzero n, szp_we_o=1. sf_o is result bit W-1. zf_o is 1 when the W-bit result is zero. pf_o is 1 when result bits 7..0 hold an even number of ones.
- R9: When wide_i=0, only bits 15..0 of dst_i and src_i are used, and res_o[31:16] is zero.
- R10: Each flag output is 0 while its enable is 0.
- R11: Three chained 16-bit right shifts pack a date: by 7 from a year (0..99), then by 5 from a day (1..31), then by 4 from a month (1..12). The result is month in bits 15..12, day in bits 11..7 and year in bits 6..0.
- R12: Four chained 16-bit left shifts by 4 gather the top nibble of each source word. The first source's nibble ends in bits 15..12 and the last source's nibble ends in bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 32 | Destination operand (low 16 bits in 16-bit mode) |
| src_i | input | 32 | Fill operand, read only |
| cnt_i | input | 8 | Shift count, low 5 bits used |
| dir_i | input | 1 | 0 = left, 1 = right |
| wide_i | input | 1 | 0 = 16-bit, 1 = 32-bit |
| res_o | output | 32 | Shifted destination |
| cf_o | output | 1 | Carry value |
| of_o | output | 1 | Overflow value |
| sf_o | output | 1 | Sign value |
| zf_o | output | 1 | Zero value |
| pf_o | output | 1 | Parity value |
| cf_we_o | output | 1 | Carry update enable |
| of_we_o | output | 1 | Overflow update enable |
| szp_we_o | output | 1 | Sign/zero/parity update enable |
| cnt_bad_o | output | 1 | Count out of range for 16-bit width |

## Verification
All results are combinational, so each output is due in the same cycle as the inputs that produce it, with no register delay. The driver changes inputs on the falling clock edge and records the expected item at that moment. The monitor pops and compares the item on the following rising edge, half a period later, when the outputs have settled and before the next drive. The chained sequences feed each step's modelled result into the next destination. Each sequence's final word is also compared against a constant worked out by hand.

// File: rtl/dshift_pkg.sv
package dshift_pkg;
  localparam int unsigned MAX_W    = 32;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned CNT_W    = $clog2(MAX_W);

  typedef enum logic {DIR_LEFT = 1'b0, DIR_RIGHT = 1'b1} dir_e;
  typedef enum logic {SZ_16 = 1'b0, SZ_32 = 1'b1} size_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic pf;
  } flags_t;

  typedef struct packed {
    logic cf;
    logic of;
    logic szp;
  } flag_we_t;
endpackage

// File: rtl/dshift_count.sv
module dshift_count
  import dshift_pkg::*;
#(
  parameter int unsigned MAX_W    = dshift_pkg::MAX_W,
  parameter int unsigned NARROW_W = dshift_pkg::NARROW_W,
  parameter int unsigned CNT_IN_W = 8
) (
  input  logic [CNT_IN_W-1:0]        cnt_i,
  input  size_e                      size_i,
  output logic [$clog2(MAX_W)-1:0]   cnt_o,
  output logic                       zero_o,
  output logic                       one_o,
  output logic                       bad_o,
  output logic                       live_o
);
  localparam int unsigned CW = $clog2(MAX_W);

  logic unused_cnt_hi;
  assign unused_cnt_hi = ^cnt_i[CNT_IN_W-1:CW];

  assign cnt_o  = cnt_i[CW-1:0];
  assign zero_o = (cnt_o == '0);
  assign one_o  = (cnt_o == CW'(1));
  assign bad_o  = (size_i == SZ_16) && (int'(cnt_o) >= int'(NARROW_W));
  assign live_o = !zero_o && !bad_o;

  always_comb begin
    if (live_o) begin
      a_r6_live_in_range: assert ((size_i == SZ_32) || (int'(cnt_o) < int'(NARROW_W)))
        else $error("live count out of range");
    end
  end
endmodule

// File: rtl/dshift_funnel.sv
module dshift_funnel
  import dshift_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]          dst_i,
  input  logic [W-1:0]          src_i,
  input  dir_e                  dir_i,
  input  logic [$clog2(W)-1:0]  cnt_i,
  output logic [W-1:0]          res_o,
  output logic                  cout_o
);
  localparam int unsigned SW = $clog2(W);
  localparam int unsigned VW = 2 * W + 1;

  logic [VW-1:0] stg [SW+1];

  // left: {guard, dst, src}; right: {src, dst, guard}
  assign stg[0] = (dir_i == DIR_LEFT) ? {1'b0, dst_i, src_i} : {src_i, dst_i, 1'b0};

  for (genvar g = 0; g < SW; g++) begin : g_stage
    localparam int unsigned SH = 1 << g;
    logic [VW-1:0] moved;
    assign moved      = (dir_i == DIR_LEFT) ? (stg[g] << SH) : (stg[g] >> SH);
    assign stg[g + 1] = cnt_i[g] ? moved : stg[g];
  end

  always_comb begin
    if (dir_i == DIR_LEFT) begin
      res_o  = stg[SW][2*W-1:W];
      cout_o = stg[SW][2*W];
    end else begin
      res_o  = stg[SW][W:1];
      cout_o = stg[SW][0];
    end
  end

  int lidx, ridx;
  always_comb begin
    lidx = int'(W) - int'(cnt_i);
    ridx = int'(cnt_i) - 1;
    if (cnt_i == '0) begin
      a_r5_hold: assert (res_o == dst_i) else $error("zero count altered dst");
    end else if (dir_i == DIR_LEFT) begin
      a_r1_fill_lsb: assert (res_o[0] == src_i[lidx[SW-1:0]])
        else $error("left fill bit wrong");
      a_r3_left_carry: assert (cout_o == dst_i[lidx[SW-1:0]])
        else $error("left carry wrong");
    end else begin
      a_r2_fill_msb: assert (res_o[W-1] == src_i[ridx[SW-1:0]])
        else $error("right fill bit wrong");
      a_r3_right_carry: assert (cout_o == dst_i[ridx[SW-1:0]])
        else $error("right carry wrong");
    end
  end
endmodule

// File: rtl/dshift_flags.sv
module dshift_flags
  import dshift_pkg::*;
#(
  parameter int unsigned MAX_W    = dshift_pkg::MAX_W,
  parameter int unsigned NARROW_W = dshift_pkg::NARROW_W
) (
  input  logic [MAX_W-1:0] res_i,
  input  logic             dst_msb_i,
  input  logic             cout_i,
  input  size_e            size_i,
  input  logic             live_i,
  input  logic             one_i,
  output flags_t           flags_o,
  output flag_we_t         we_o
);
  logic res_msb, res_zero, res_par;

  assign res_msb  = (size_i == SZ_32) ? res_i[MAX_W-1] : res_i[NARROW_W-1];
  assign res_zero = (size_i == SZ_32) ? (res_i == '0) : (res_i[NARROW_W-1:0] == '0);
  assign res_par  = ~^res_i[7:0];

  always_comb begin
    we_o.cf  = live_i;
    we_o.szp = live_i;
    we_o.of  = live_i && one_i;
    flags_o.cf = we_o.cf  && cout_i;
    flags_o.of = we_o.of  && (res_msb ^ dst_msb_i);
    flags_o.sf = we_o.szp && res_msb;
    flags_o.zf = we_o.szp && res_zero;
    flags_o.pf = we_o.szp && res_par;
  end

  always_comb begin
    if (we_o.of) begin
      a_r7_of_implies_cf: assert (we_o.cf && we_o.szp) else $error("of enable alone");
    end
    if (!live_i) begin
      a_r10_quiet_flags: assert (flags_o == '0) else $error("flag set while disabled");
    end
    if (we_o.szp && res_zero) begin
      a_r8_zero_no_sign: assert (!flags_o.sf && flags_o.pf) else $error("zero result flags");
    end
  end
endmodule

// File: rtl/dshift_unit.sv
module dshift_unit
  import dshift_pkg::*;
#(
  parameter int unsigned MAX_W    = dshift_pkg::MAX_W,
  parameter int unsigned NARROW_W = dshift_pkg::NARROW_W,
  parameter int unsigned CNT_IN_W = 8
) (
  input  logic [MAX_W-1:0]    dst_i,
  input  logic [MAX_W-1:0]    src_i,
  input  logic [CNT_IN_W-1:0] cnt_i,
  input  logic                dir_i,
  input  logic                wide_i,
  output logic [MAX_W-1:0]    res_o,
  output logic                cf_o,
  output logic                of_o,
  output logic                sf_o,
  output logic                zf_o,
  output logic                pf_o,
  output logic                cf_we_o,
  output logic                of_we_o,
  output logic                szp_we_o,
  output logic                cnt_bad_o
);
  localparam int unsigned CW  = $clog2(MAX_W);
  localparam int unsigned NCW = $clog2(NARROW_W);

  size_e size;
  dir_e  dir;
  assign size = size_e'(wide_i);
  assign dir  = dir_e'(dir_i);

  logic [CW-1:0] cnt;
  logic cnt_zero, cnt_one, cnt_bad, cnt_live;

  dshift_count #(
    .MAX_W(MAX_W), .NARROW_W(NARROW_W), .CNT_IN_W(CNT_IN_W)
  ) i_count (
    .cnt_i (cnt_i),
    .size_i(size),
    .cnt_o (cnt),
    .zero_o(cnt_zero),
    .one_o (cnt_one),
    .bad_o (cnt_bad),
    .live_o(cnt_live)
  );

  logic [MAX_W-1:0]    w_res;
  logic                w_cout;
  logic [NARROW_W-1:0] n_res;
  logic                n_cout;

  dshift_funnel #(.W(MAX_W)) i_funnel_wide (
    .dst_i (dst_i),
    .src_i (src_i),
    .dir_i (dir),
    .cnt_i (cnt),
    .res_o (w_res),
    .cout_o(w_cout)
  );

  dshift_funnel #(.W(NARROW_W)) i_funnel_narrow (
    .dst_i (dst_i[NARROW_W-1:0]),
    .src_i (src_i[NARROW_W-1:0]),
    .dir_i (dir),
    .cnt_i (cnt[NCW-1:0]),
    .res_o (n_res),
    .cout_o(n_cout)
  );

  logic [MAX_W-1:0] dst_sel, res_sel;
  logic             cout_sel, dst_msb;

  always_comb begin
    if (size == SZ_32) begin
      dst_sel  = dst_i;
      res_sel  = w_res;
      cout_sel = w_cout;
      dst_msb  = dst_i[MAX_W-1];
    end else begin
      dst_sel  = MAX_W'(dst_i[NARROW_W-1:0]);
      res_sel  = MAX_W'(n_res);
      cout_sel = n_cout;
      dst_msb  = dst_i[NARROW_W-1];
    end
  end

  assign res_o     = cnt_live ? res_sel : dst_sel;
  assign cnt_bad_o = cnt_bad;

  flags_t   flags;
  flag_we_t fwe;

  dshift_flags #(.MAX_W(MAX_W), .NARROW_W(NARROW_W)) i_flags (
    .res_i    (res_o),
    .dst_msb_i(dst_msb),
    .cout_i   (cout_sel),
    .size_i   (size),
    .live_i   (cnt_live),
    .one_i    (cnt_one),
    .flags_o  (flags),
    .we_o     (fwe)
  );

  assign cf_o     = flags.cf;
  assign of_o     = flags.of;
  assign sf_o     = flags.sf;
  assign zf_o     = flags.zf;
  assign pf_o     = flags.pf;
  assign cf_we_o  = fwe.cf;
  assign of_we_o  = fwe.of;
  assign szp_we_o = fwe.szp;

  always_comb begin
    if (cnt_bad_o) begin
      a_r6_bad_no_update: assert (!cf_we_o && !of_we_o && !szp_we_o && !wide_i)
        else $error("bad count updated flags");
    end
    if (!wide_i) begin
      a_r9_upper_clear: assert (res_o[MAX_W-1:NARROW_W] == '0)
        else $error("upper half not clear");
    end
    if (cnt_i[CW-1:0] == '0) begin
      a_r5_no_enables: assert (!cf_we_o && !of_we_o && !szp_we_o && !cnt_bad_o)
        else $error("zero count raised enables");
    end
    if (of_we_o) begin
      a_r7_single_step: assert (cnt_i[CW-1:0] == CW'(1)) else $error("of enable on count != 1");
    end
  end
endmodule

// File: tb/test_dshift_unit.sv
module test_dshift_unit;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  logic [31:0] dst, src, res;
  logic [7:0]  cnt;
  logic        dir, wide;
  logic        cf, of, sf, zf, pf, cfwe, ofwe, szpwe, bad;

  dshift_unit i_dshift_unit (
    .dst_i(dst), .src_i(src), .cnt_i(cnt), .dir_i(dir), .wide_i(wide),
    .res_o(res), .cf_o(cf), .of_o(of), .sf_o(sf), .zf_o(zf), .pf_o(pf),
    .cf_we_o(cfwe), .of_we_o(ofwe), .szp_we_o(szpwe), .cnt_bad_o(bad)
  );

  typedef struct packed {
    logic [31:0] res;
    logic cf, of, sf, zf, pf, cfwe, ofwe, szpwe, bad;
  } obs_t;

  typedef struct {
    obs_t  v;
    string tag;
  } item_t;

  item_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model: one bit per step, as in the requirement text.
  function automatic obs_t model(logic [31:0] d0, logic [31:0] s0, logic [7:0] c,
                                 logic dr, logic wd);
    obs_t o;
    int w = wd ? 32 : 16;
    int n = int'(c & 8'h1f);
    logic [31:0] msk = wd ? 32'hffff_ffff : 32'h0000_ffff;
    logic [31:0] d = d0 & msk;
    logic [31:0] s = s0 & msk;
    logic [31:0] orig = d;
    logic c_out = 1'b0;
    int ones = 0;
    o = '0;
    if (n == 0) begin
      o.res = d;
      return o;
    end
    if (!wd && n >= 16) begin
      o.res = d;
      o.bad = 1'b1;
      return o;
    end
    for (int i = 0; i < n; i++) begin
      if (!dr) begin
        c_out = d[w-1];
        d = ((d << 1) | 32'(s[w-1])) & msk;
        s = (s << 1) & msk;
      end else begin
        c_out = d[0];
        d = (d >> 1) | (32'(s[0]) << (w - 1));
        s = s >> 1;
      end
    end
    for (int b = 0; b < 8; b++) ones += int'(d[b]);
    o.res   = d;
    o.cfwe  = 1'b1;
    o.szpwe = 1'b1;
    o.cf    = c_out;
    o.ofwe  = (n == 1);
    o.of    = (n == 1) && (d[w-1] != orig[w-1]);
    o.sf    = d[w-1];
    o.zf    = (d == 0);
    o.pf    = (ones % 2 == 0);
    return o;
  endfunction

  task automatic drive(input logic [31:0] d, input logic [31:0] s, input logic [7:0] c,
                       input logic dr, input logic wd, input string tag,
                       output logic [31:0] exp_res);
    item_t it;
    @(negedge clk);
    dst = d; src = s; cnt = c; dir = dr; wide = wd;
    it.v = model(d, s, c, dr, wd);
    it.tag = tag;
    exp_res = it.v.res;
    q.push_back(it);
  endtask

  task automatic check_word(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: result is due half a period after the falling-edge drive.
  always @(posedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      obs_t act;
      it = q.pop_front();
      act = '{res, cf, of, sf, zf, pf, cfwe, ofwe, szpwe, bad};
      n_run++;
      if (act !== it.v) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.v);
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL all-reqs watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    dst = '0; src = '0; cnt = '0; dir = 1'b0; wide = 1'b1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    drive(32'h0, 32'h0, 8'd0, 1'b0, 1'b1, "R5 reset-state idle", r);
    drive(32'h1234_5678, 32'h9abc_def0, 8'd0, 1'b1, 1'b1, "R5 zero count 32", r);
    drive(32'hdead_beef, 32'h5555_5555, 8'd8, 1'b0, 1'b1, "R1 R3 left32 by 8", r);
    drive(32'h8000_0001, 32'hf0f0_0f0f, 8'd31, 1'b0, 1'b1, "R1 left32 by 31", r);
    drive(32'hcafe_babe, 32'h0000_0abc, 8'd12, 1'b1, 1'b1, "R2 R3 right32 by 12", r);
    drive(32'h0000_00ff, 32'h7fff_fffe, 8'd31, 1'b1, 1'b1, "R2 right32 by 31", r);
    drive(32'h4000_0000, 32'h0, 8'd1, 1'b0, 1'b1, "R7 of set left by 1", r);
    drive(32'hc000_0000, 32'h0, 8'd1, 1'b0, 1'b1, "R7 of clear left by 1", r);
    drive(32'h0000_0001, 32'h0, 8'd1, 1'b1, 1'b1, "R7 R8 right by 1 zero", r);
    drive(32'h4000_0000, 32'h0, 8'd2, 1'b0, 1'b1, "R7 no of update count 2", r);
    drive(32'hdead_beef, 32'h5555_5555, 8'he8, 1'b0, 1'b1, "R4 mask count e8->8", r);
    drive(32'h4000_0000, 32'h0, 8'h21, 1'b0, 1'b1, "R4 mask count 21->1", r);
    drive(32'hffff_1234, 32'hffff_8001, 8'd3, 1'b0, 1'b0, "R9 left16 upper ignored", r);
    drive(32'h0000_0003, 32'habcd_0001, 8'd15, 1'b1, 1'b0, "R9 R3 right16 by 15", r);
    drive(32'h0000_8000, 32'h0, 8'd1, 1'b1, 1'b0, "R7 R8 right16 by 1", r);
    drive(32'h0000_00f3, 32'h0, 8'd4, 1'b1, 1'b0, "R8 R10 parity", r);
    drive(32'h1111_a5a5, 32'h2222_5a5a, 8'd16, 1'b0, 1'b0, "R6 count 16 at width 16", r);
    drive(32'h0000_7777, 32'h1, 8'd20, 1'b1, 1'b0, "R6 count 20 at width 16", r);
    drive(32'h0000_7777, 32'h1, 8'd16, 1'b1, 1'b1, "R6 count 16 valid at 32", r);

    // Date pack (R11): year 99, day 31, month 12 -> 16'hcfe3.
    drive(32'h0000_5a5a, 32'd99, 8'd7, 1'b1, 1'b0, "R11 pack year", r);
    drive(r, 32'd31, 8'd5, 1'b1, 1'b0, "R11 pack day", r);
    drive(r, 32'd12, 8'd4, 1'b1, 1'b0, "R11 pack month", r);
    @(posedge clk); #1;
    check_word(res, 32'h0000_cfe3, "R11 date word");

    // Nibble gather (R12): tops a,b,c,d -> 16'habcd.
    drive(32'h0000_0000, 32'h0000_a123, 8'd4, 1'b0, 1'b0, "R12 gather 1", r);
    drive(r, 32'h0000_b456, 8'd4, 1'b0, 1'b0, "R12 gather 2", r);
    drive(r, 32'h0000_c789, 8'd4, 1'b0, 1'b0, "R12 gather 3", r);
    drive(r, 32'h0000_dabc, 8'd4, 1'b0, 1'b0, "R12 gather 4", r);
    @(posedge clk); #1;
    check_word(res, 32'h0000_abcd, "R12 gathered word");

    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule